// File: doc/BRIEF.md
# Configurable Cell Inlet Port

This block receives fixed-length cells, one byte at a time, from an external device over an 8-bit cell bus. It uses a start-of-cell strobe, an active-low enable and a cell-available flag. It hands each byte to an internal cell FIFO, tagged with first-byte and last-byte markers. The same transfer engine serves two roles, chosen by a static input:

- **Master role (ATM-layer side).** The port generates the interface clock and drives the enable. It reads cell-available from the attached device.
- **Slave role (PHY-layer side).** The port takes the interface clock and the enable from the attached device. It reports cell-available back to it.

Cell length is static. It is either a plain 53-byte cell, or a cell preceded by 2 or 4 routing-header bytes, which gives 55 or 57 bytes. When header translation is enabled upstream, the length is always 53, because the header bytes are then added elsewhere.

All logic runs on one system clock. The interface clock and the three reference clocks are treated as slow signals and are edge-detected in that domain. In the master role, the interface clock is one of three reference clocks divided by two.

Top module: `cellport_top`

## Requirements
- R1: With translation off, length code 000 gives 53-byte cells, 001 gives 55-byte cells and 010 gives 57-byte cells.
- R2: With translation on (`cfg_xlate_i` = 1), every cell is 53 bytes, whatever the length code.
- R3: Any length code from 011 to 111 raises `cfg_err_o` and is treated as 53 bytes.
- R4: Bytes reach `cell_data_o` in arrival order, each with one `cell_valid_o` pulse. `cell_sop_o` marks the first byte of a cell and `cell_eop_o` marks the byte at position length-1. The byte counter wraps at that point, so back-to-back cells need no gap.
- R5: A byte is taken only on a rising edge of the interface clock at which the enable is low. An edge with the enable high transfers nothing.
- R6: At a cell boundary, a byte that arrives without `u_soc_i` is discarded.
- R7: If `u_soc_i` arrives in the middle of a cell, `proto_err_o` pulses for one cycle together with the byte. That byte then starts a new cell, marked with `cell_sop_o`.
- R8: In the slave role, `u_clav_o` equals `fifo_room_i` at a cell boundary and stays 1 in the middle of a cell. In the master role, `u_clav_o` is 0.
- R9: In the master role, `u_enb_n_o` goes low at an interface-clock rise that leaves the port at a cell boundary, provided `u_clav_i` and `fifo_room_i` are both 1. It stays low across back-to-back cells and goes high at a boundary where either is 0. In the slave role, `u_enb_n_o` is 1.
- R10: In the master role, `uclk_o` toggles on each rising edge of the selected reference clock: select 00 is the bus clock, 01 the line clock and 10 the processor clock. Edges of the other reference clocks have no effect. `uclk_oe_o` equals the role input, and `uclk_o` is 0 in the slave role.
- R11: Select code 11 holds `uclk_o` low and raises `clk_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_role_atm_i | input | 1 | 1 = master (ATM-layer) role, 0 = slave (PHY-layer) role |
| cfg_len_mode_i | input | 3 | Cell length code |
| cfg_xlate_i | input | 1 | Header translation on; forces 53-byte cells |
| cfg_clk_sel_i | input | 2 | Reference clock select for the master role |
| ref_bus_i | input | 1 | Bus reference clock |
| ref_line_i | input | 1 | Line reference clock |
| ref_proc_i | input | 1 | Processor reference clock |
| uclk_o | output | 1 | Generated interface clock |
| uclk_oe_o | output | 1 | Output enable for the interface clock |
| uclk_i | input | 1 | Interface clock from the device (slave role) |
| u_enb_n_o | output | 1 | Active-low enable driven by the port (master role) |
| u_enb_n_i | input | 1 | Active-low enable from the device (slave role) |
| u_clav_o | output | 1 | Cell available, driven by the port (slave role) |
| u_clav_i | input | 1 | Cell available from the device (master role) |
| u_soc_i | input | 1 | Start of cell |
| u_data_i | input | 8 | Cell byte |
| fifo_room_i | input | 1 | FIFO has room for one whole cell |
| cell_data_o | output | 8 | Byte to the FIFO |
| cell_valid_o | output | 1 | Byte strobe |
| cell_sop_o | output | 1 | First byte of a cell |
| cell_eop_o | output | 1 | Last byte of a cell |
| cfg_err_o | output | 1 | Invalid length code |
| clk_err_o | output | 1 | Reserved clock select |
| proto_err_o | output | 1 | Start-of-cell in the middle of a cell |

## Verification
A wrong byte count shows within one cell. It moves `cell_eop_o` away from the byte the bench expects to close the cell, and the next cell then starts without `cell_sop_o`. A stuck enable or role state shows at the next interface-clock rise, either as a missing `cell_valid_o` pulse or as a byte taken while the enable is high. A wrong divider or clock-select state shows within two reference edges as a `uclk_o` that fails to toggle, or toggles when it should not.

// File: rtl/cellport_pkg.sv
package cellport_pkg;
    localparam int DATA_W    = 8;
    localparam int BASE_LEN  = 53;
    localparam int HDR_SHORT = 2;
    localparam int HDR_LONG  = 4;
    localparam int MAX_LEN   = BASE_LEN + HDR_LONG;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    typedef enum logic [1:0] {
        SRC_BUS  = 2'b00,
        SRC_LINE = 2'b01,
        SRC_PROC = 2'b10,
        SRC_RSVD = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sop;
        logic              eop;
    } cell_beat_t;

    function automatic logic [CNT_W-1:0] cell_len(input logic [2:0] code, input logic xlate);
        if (xlate) return CNT_W'(BASE_LEN);
        case (code)
            3'b001:  return CNT_W'(BASE_LEN + HDR_SHORT);
            3'b010:  return CNT_W'(BASE_LEN + HDR_LONG);
            default: return CNT_W'(BASE_LEN);
        endcase
    endfunction

    function automatic logic code_bad(input logic [2:0] code);
        return code > 3'b010;
    endfunction
endpackage

// File: rtl/cellport_cfg.sv
module cellport_cfg
    import cellport_pkg::*;
(
    input  logic [2:0]       len_code,
    input  logic             xlate,
    input  logic [1:0]       clk_sel,
    output logic [CNT_W-1:0] len,
    output logic             len_err,
    output logic             sel_err
);
    always_comb begin
        len     = cell_len(len_code, xlate);
        len_err = code_bad(len_code);
        sel_err = (clk_src_e'(clk_sel) == SRC_RSVD);
    end
endmodule

// File: rtl/cellport_clkgen.sv
module cellport_clkgen
    import cellport_pkg::*;
#(
    parameter int N_REF = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       clk_sel,
    input  logic [N_REF-1:0] refs,
    output logic             uclk,
    output logic             rise_tick
);
    logic [N_REF-1:0] ref_q;
    logic [N_REF-1:0] ref_edge;
    logic             sel_edge;
    logic             uclk_q;

    genvar g;
    generate
        for (g = 0; g < N_REF; g++) begin : g_edge
            always_ff @(posedge clk) begin
                if (rst) ref_q[g] <= 1'b0;
                else     ref_q[g] <= refs[g];
            end
            assign ref_edge[g] = refs[g] & ~ref_q[g];
        end
    endgenerate

    always_comb begin
        case (clk_src_e'(clk_sel))
            SRC_BUS:  sel_edge = ref_edge[0];
            SRC_LINE: sel_edge = ref_edge[1];
            SRC_PROC: sel_edge = ref_edge[2];
            default:  sel_edge = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                                    uclk_q <= 1'b0;
        else if (clk_src_e'(clk_sel) == SRC_RSVD)   uclk_q <= 1'b0;
        else if (sel_edge)                          uclk_q <= ~uclk_q;
    end

    assign uclk      = uclk_q;
    assign rise_tick = sel_edge & ~uclk_q;
endmodule

// File: rtl/cellport_engine.sv
module cellport_engine
    import cellport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              master,
    input  logic [CNT_W-1:0]  len,
    input  logic              ext_enb_n,
    input  logic              soc,
    input  logic [DATA_W-1:0] data,
    input  logic              peer_clav,
    input  logic              room,
    output logic              own_enb_n,
    output logic              own_clav,
    output logic              out_valid,
    output cell_beat_t        out_beat,
    output logic              perr
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             enb_q, enb_d;
    logic             xfer, emit, perr_d;
    cell_beat_t       beat_d;

    assign xfer = tick & ~(master ? enb_q : ext_enb_n);

    always_comb begin
        cnt_d  = cnt_q;
        emit   = 1'b0;
        perr_d = 1'b0;
        beat_d = '0;
        if (xfer) begin
            if (soc) begin
                emit        = 1'b1;
                perr_d      = (cnt_q != '0);
                beat_d.data = data;
                beat_d.sop  = 1'b1;
                cnt_d       = CNT_W'(1);
            end else if (cnt_q != '0) begin
                emit        = 1'b1;
                beat_d.data = data;
                beat_d.eop  = (cnt_q >= len - CNT_W'(1));
                cnt_d       = beat_d.eop ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        enb_d = enb_q;
        if (!master)
            enb_d = 1'b1;
        else if (tick)
            enb_d = (cnt_d == '0) ? ~(peer_clav & room) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            enb_q     <= 1'b1;
            out_valid <= 1'b0;
            out_beat  <= '0;
            perr      <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            enb_q     <= enb_d;
            out_valid <= emit;
            out_beat  <= beat_d;
            perr      <= perr_d;
        end
    end

    assign own_enb_n = enb_q;
    assign own_clav  = ~master & ((cnt_q != '0) | room);
endmodule

// File: rtl/cellport_top.sv
module cellport_top
    import cellport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_role_atm_i,
    input  logic [2:0]        cfg_len_mode_i,
    input  logic              cfg_xlate_i,
    input  logic [1:0]        cfg_clk_sel_i,
    input  logic              ref_bus_i,
    input  logic              ref_line_i,
    input  logic              ref_proc_i,
    output logic              uclk_o,
    output logic              uclk_oe_o,
    input  logic              uclk_i,
    output logic              u_enb_n_o,
    input  logic              u_enb_n_i,
    output logic              u_clav_o,
    input  logic              u_clav_i,
    input  logic              u_soc_i,
    input  logic [DATA_W-1:0] u_data_i,
    input  logic              fifo_room_i,
    output logic [DATA_W-1:0] cell_data_o,
    output logic              cell_valid_o,
    output logic              cell_sop_o,
    output logic              cell_eop_o,
    output logic              cfg_err_o,
    output logic              clk_err_o,
    output logic              proto_err_o
);
    logic [CNT_W-1:0] len;
    logic             gen_clk, m_tick, s_tick, port_tick, uclk_i_q;
    cell_beat_t       beat;

    cellport_cfg u_cfg (
        .len_code (cfg_len_mode_i),
        .xlate    (cfg_xlate_i),
        .clk_sel  (cfg_clk_sel_i),
        .len      (len),
        .len_err  (cfg_err_o),
        .sel_err  (clk_err_o)
    );

    cellport_clkgen #(.N_REF(3)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .clk_sel   (cfg_clk_sel_i),
        .refs      ({ref_proc_i, ref_line_i, ref_bus_i}),
        .uclk      (gen_clk),
        .rise_tick (m_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) uclk_i_q <= 1'b0;
        else     uclk_i_q <= uclk_i;
    end
    assign s_tick    = uclk_i & ~uclk_i_q;
    assign port_tick = cfg_role_atm_i ? m_tick : s_tick;

    cellport_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .tick      (port_tick),
        .master    (cfg_role_atm_i),
        .len       (len),
        .ext_enb_n (u_enb_n_i),
        .soc       (u_soc_i),
        .data      (u_data_i),
        .peer_clav (u_clav_i),
        .room      (fifo_room_i),
        .own_enb_n (u_enb_n_o),
        .own_clav  (u_clav_o),
        .out_valid (cell_valid_o),
        .out_beat  (beat),
        .perr      (proto_err_o)
    );

    assign uclk_o      = cfg_role_atm_i & gen_clk;
    assign uclk_oe_o   = cfg_role_atm_i;
    assign cell_data_o = beat.data;
    assign cell_sop_o  = beat.sop;
    assign cell_eop_o  = beat.eop;
endmodule

// File: rtl/cellport_chk.sv
module cellport_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_clk_sel_i,
    input logic       cfg_role_atm_i,
    input logic       uclk_o,
    input logic       u_enb_n_o,
    input logic       cell_valid_o,
    input logic       cell_sop_o,
    input logic       cell_eop_o,
    input logic       proto_err_o,
    input logic       port_tick
);
    assert_sop_valid_R4: assert property (@(posedge clk) disable iff (rst)
        cell_sop_o |-> cell_valid_o);

    assert_eop_valid_R4: assert property (@(posedge clk) disable iff (rst)
        cell_eop_o |-> cell_valid_o);

    assert_byte_on_edge_R5: assert property (@(posedge clk) disable iff (rst)
        cell_valid_o |-> $past(port_tick));

    assert_restart_sop_R7: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |-> cell_sop_o);

    assert_slave_enb_high_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_role_atm_i && $past(!cfg_role_atm_i)) |-> u_enb_n_o);

    assert_rsvd_clk_low_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_clk_sel_i == 2'b11) |=> !uclk_o);
endmodule

bind cellport_top cellport_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_clk_sel_i  (cfg_clk_sel_i),
    .cfg_role_atm_i (cfg_role_atm_i),
    .uclk_o         (uclk_o),
    .u_enb_n_o      (u_enb_n_o),
    .cell_valid_o   (cell_valid_o),
    .cell_sop_o     (cell_sop_o),
    .cell_eop_o     (cell_eop_o),
    .proto_err_o    (proto_err_o),
    .port_tick      (port_tick)
);

// File: tb/tb_cellport_top.sv
`timescale 1ns/1ps
module tb_cellport_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       role = 1'b0, xlate = 1'b0;
    logic [2:0] lmode = 3'b000;
    logic [1:0] csel = 2'b01;
    logic [2:0] refs = 3'b000;
    logic       uclk_i = 1'b0, enb_n_i = 1'b1, clav_i = 1'b0, soc = 1'b0, room = 1'b1;
    logic [7:0] din = 8'h00;
    logic       uclk_o, uclk_oe, enb_n_o, clav_o, vld, sop, eop, cfg_err, clk_err, perr;
    logic [7:0] dout;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    cellport_top dut (
        .clk(clk), .rst(rst), .cfg_role_atm_i(role), .cfg_len_mode_i(lmode),
        .cfg_xlate_i(xlate), .cfg_clk_sel_i(csel),
        .ref_bus_i(refs[0]), .ref_line_i(refs[1]), .ref_proc_i(refs[2]),
        .uclk_o(uclk_o), .uclk_oe_o(uclk_oe), .uclk_i(uclk_i),
        .u_enb_n_o(enb_n_o), .u_enb_n_i(enb_n_i), .u_clav_o(clav_o), .u_clav_i(clav_i),
        .u_soc_i(soc), .u_data_i(din), .fifo_room_i(room),
        .cell_data_o(dout), .cell_valid_o(vld), .cell_sop_o(sop), .cell_eop_o(eop),
        .cfg_err_o(cfg_err), .clk_err_o(clk_err), .proto_err_o(perr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Slave role: one interface clock rise, outputs sampled one edge later.
    task automatic slave_byte(input bit s, input logic [7:0] d, input bit en_n);
        @(negedge clk);
        uclk_i = 1'b1; soc = s; din = d; enb_n_i = en_n;
        @(negedge clk);
        uclk_i = 1'b0; soc = 1'b0; enb_n_i = 1'b1;
    endtask

    // Master role: pulse the selected reference until the port clock rises.
    task automatic master_tick(input int which);
        bit prev, now;
        prev = uclk_o;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); refs[which] = 1'b1;
            @(negedge clk); now = uclk_o; refs[which] = 1'b0;
            if (!prev && now) return;
            prev = now;
        end
    endtask

    // Bytes leave in order with sop on the first and eop on the last byte.
    task automatic slave_cells(input logic [2:0] m, input bit x, input int len, input int n, input string tag);
        int bad;
        lmode = m; xlate = x; room = 1'b1;
        for (int c = 0; c < n; c++) begin
            bad = 0;
            for (int i = 0; i < len; i++) begin
                slave_byte(i == 0, 8'(c * 11 + i), 1'b0);
                if (!vld || dout != 8'(c * 11 + i) || sop != (i == 0) || eop != (i == len - 1)) bad++;
            end
            check(bad == 0, tag, bad, 0);
        end
    endtask

    task automatic test_reset;
        check(!vld && !sop && !eop && !perr, "R4 reset outputs idle", vld, 0);
        check(enb_n_o == 1'b1, "R9 reset enable high", enb_n_o, 1);
        check(uclk_o == 1'b0 && uclk_oe == 1'b0, "R10 slave clock off", uclk_o, 0);
    endtask

    task automatic test_lengths;
        slave_cells(3'b000, 1'b0, 53, 2, "R1 53-byte cells");
        slave_cells(3'b001, 1'b0, 55, 2, "R1 55-byte cells");
        slave_cells(3'b010, 1'b0, 57, 2, "R1 57-byte cells");
        slave_cells(3'b010, 1'b1, 53, 2, "R2 translation forces 53");
        #1 check(cfg_err == 1'b0, "R3 valid code no error", cfg_err, 0);
        lmode = 3'b101; #1;
        check(cfg_err == 1'b1, "R3 bad code flags error", cfg_err, 1);
        slave_cells(3'b101, 1'b0, 53, 1, "R3 bad code gives 53");
        lmode = 3'b000;
    endtask

    task automatic test_gating;
        slave_byte(1'b1, 8'hA5, 1'b1);
        check(vld == 1'b0, "R5 enable high ignored", vld, 0);
        slave_byte(1'b0, 8'h3C, 1'b0);
        check(vld == 1'b0, "R6 no start at boundary dropped", vld, 0);
        slave_cells(3'b000, 1'b0, 53, 1, "R5 cell after ignored bytes");
    endtask

    task automatic test_proto;
        int bad = 0;
        for (int i = 0; i < 5; i++) slave_byte(i == 0, 8'(i), 1'b0);
        check(perr == 1'b0, "R7 no error in order", perr, 0);
        slave_byte(1'b1, 8'h77, 1'b0);
        check(perr == 1'b1 && sop == 1'b1 && dout == 8'h77, "R7 mid-cell start", perr, 1);
        for (int i = 1; i < 53; i++) begin
            slave_byte(1'b0, 8'(i), 1'b0);
            if (eop != (i == 52) || perr) bad++;
        end
        check(bad == 0, "R7 restarted count", bad, 0);
    endtask

    task automatic test_clav;
        room = 1'b1; #1;
        check(clav_o == 1'b1, "R8 clav with room", clav_o, 1);
        room = 1'b0; #1;
        check(clav_o == 1'b0, "R8 no clav without room", clav_o, 0);
        room = 1'b1;
        slave_byte(1'b1, 8'h10, 1'b0);
        room = 1'b0; #1;
        check(clav_o == 1'b1, "R8 clav held mid-cell", clav_o, 1);
        room = 1'b1;
        for (int i = 1; i < 53; i++) slave_byte(1'b0, 8'(i), 1'b0);
    endtask

    task automatic test_master;
        int bad = 0;
        role = 1'b1; csel = 2'b01; clav_i = 1'b1; room = 1'b1; lmode = 3'b001;
        #1 check(uclk_oe == 1'b1 && clav_o == 1'b0, "R8 R10 master drives clock", uclk_oe, 1);
        master_tick(1);
        check(enb_n_o == 1'b0, "R9 enable asserted", enb_n_o, 0);
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 55; i++) begin
                soc = (i == 0); din = 8'(c * 5 + i);
                if (c == 1 && i == 54) clav_i = 1'b0;
                master_tick(1);
                if (!vld || dout != 8'(c * 5 + i) || sop != (i == 0) || eop != (i == 54)) bad++;
                if (!(c == 1 && i == 54) && enb_n_o) bad++;
            end
        check(bad == 0, "R9 R4 master back-to-back", bad, 0);
        check(enb_n_o == 1'b1, "R9 enable released", enb_n_o, 1);
        soc = 1'b1; din = 8'hEE;
        master_tick(1);
        check(vld == 1'b0, "R5 master idle edge", vld, 0);
        soc = 1'b0;
    endtask

    task automatic test_clksel;
        bit u0;
        csel = 2'b00; u0 = uclk_o;
        @(negedge clk); refs[1] = 1'b1; @(negedge clk); refs[1] = 1'b0;
        check(uclk_o == u0, "R10 unselected ref ignored", uclk_o, u0);
        @(negedge clk); refs[0] = 1'b1; @(negedge clk); refs[0] = 1'b0;
        check(uclk_o == !u0, "R10 bus ref toggles", uclk_o, !u0);
        csel = 2'b10; u0 = uclk_o;
        @(negedge clk); refs[2] = 1'b1; @(negedge clk); refs[2] = 1'b0;
        check(uclk_o == !u0, "R10 proc ref toggles", uclk_o, !u0);
        csel = 2'b11;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); refs = 3'b111; @(negedge clk); refs = 3'b000;
        end
        check(uclk_o == 1'b0 && clk_err == 1'b1, "R11 reserved select", uclk_o, 0);
        csel = 2'b01;
        #1 check(clk_err == 1'b0, "R11 error clears", clk_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_lengths();
        test_gating();
        test_proto();
        test_clav();
        test_master();
        test_clksel();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule